// File: doc/BRIEF.md
# Host Memory-Bus Front End

This block connects the asynchronous external memory bus of a host processor to a set of on-chip peripheral cores. It runs entirely on the bus clock, which has a 10 ns period in its intended setting. Every bus input passes through the same two register stages: the active-low chip select, the active-low output and write enables, the address and the write data. The first stage can sit at the pads. The second stage carries the signal across the chip. As a result, downstream cores always see the same fixed number of clock states, whatever the asynchronous timing of the bus is.

From the registered signals the block produces several outputs for the peripheral cores:
- The six low address bits, passed through unchanged.
- The captured write data.
- A one-hot device select per sub-device, decoded from the address bits above the low six.
- A single-cycle read strobe, taken from the deasserting (rising) edge of the output enable. This strobe is suited to advancing read FIFOs.
- A single-cycle write strobe, taken from the asserting (falling) edge of the write enable. It fires only while some device is selected.

All of these leave the block on the same pipeline stage, so they are aligned with one another. On the return path, the selected device's read data is registered before it drives the bus, together with a registered output-enable for the pad driver. Read cycles carry one extra wait-state clock, so this register stage fits in the two periods the host allows.

Top module: `hbus_front`

## Requirements
- R1: While reset is asserted, the outputs are inactive: dev_sel = 0, dev_rd_stb = 0, dev_wr_stb = 0, bus_dout_en = 0, dev_addr = 0, dev_wdata = 0 and bus_dout = 0.
- R2: dev_addr equals bus_addr[5:0] as sampled two clock edges earlier.
- R3: dev_wdata equals bus_din as sampled two clock edges earlier.
- R4: If bus_cs_n was sampled low, then two edges later dev_sel is one-hot. The set bit is dev_sel[k], where k = bus_addr[7:6] from the same sample (00 selects bit 0, 11 selects bit 3).
- R5: If bus_cs_n was sampled high, then two edges later dev_sel is all zeros.
- R6: dev_rd_stb is high for exactly one cycle. It is high two edges after a sample of bus_oe_n = 1 whose previous sample was 0, and low at all other times.
- R7: dev_wr_stb is high for exactly one cycle. It is high two edges after a sample of bus_we_n = 0 whose previous sample was 1, taken together with bus_cs_n = 0. It is low at all other times.
- R8: A falling edge of bus_we_n sampled while bus_cs_n is high produces no write strobe.
- R9: bus_dout equals dev_rdata as sampled one edge earlier.
- R10: bus_dout_en is high three edges after a sample with both bus_oe_n = 0 and bus_cs_n = 0, and low three edges after any other sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_addr | input | ADDR_W (8) | Bus address |
| bus_din | input | DATA_W (16) | Write data arriving from the pads |
| dev_rdata | input | DATA_W (16) | Read data from the selected sub-device |
| dev_addr | output | LOW_W (6) | Low address bits forwarded to the sub-devices |
| dev_wdata | output | DATA_W (16) | Captured write data |
| dev_sel | output | 2**(ADDR_W-LOW_W) (4) | One-hot sub-device select |
| dev_rd_stb | output | 1 | One-cycle read strobe |
| dev_wr_stb | output | 1 | One-cycle write strobe |
| bus_dout | output | DATA_W (16) | Registered read data driven toward the pads |
| bus_dout_en | output | 1 | Pad driver enable for bus_dout |

## Verification
Write bursts target each of the four devices, with write-enable lows of different lengths. This separates a strobe derived from the edge from one derived from the level, and it shows that the two select bits map to the correct one-hot position. Read bursts with long and short output-enable lows show that the read strobe comes from the trailing edge and not the leading one. They also check the three-edge timing of the data-driver enable. Write-enable toggles with the chip select held high separate the select-qualified write strobe from an unqualified one. Two back-to-back write pulses only one cycle apart, and a chip select that falls in the same sample as the write enable, test whether the delayed copy of each control line is aligned correctly.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  // Control lines of the host bus, all active low.
  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } hb_ctl_t;

  localparam hb_ctl_t HB_CTL_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

  // Low-to-high transition between a delayed copy and the current copy.
  function automatic logic hb_rise(input logic older, input logic newer);
    return newer & ~older;
  endfunction

  // High-to-low transition between a delayed copy and the current copy.
  function automatic logic hb_fall(input logic older, input logic newer);
    return older & ~newer;
  endfunction

endpackage

// File: rtl/hbus_pipe.sv
// Shift chain of STAGES registers; every stage is exposed as a tap.
module hbus_pipe #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [W-1:0]               d,
  output logic [STAGES-1:0][W-1:0]   taps
);

  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign taps = st;

endmodule

// File: rtl/hbus_cs_decode.sv
// Registered one-hot decode of the upper address bits, gated by chip select.
module hbus_cs_decode #(
  parameter int unsigned HI_W = 2,
  localparam int unsigned NDEV = 1 << HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n_s1,
  input  logic [HI_W-1:0] hi_s1,
  output logic [NDEV-1:0] sel
);

  logic [NDEV-1:0] dec;

  for (genvar g = 0; g < NDEV; g++) begin : g_dec
    assign dec[g] = ~cs_n_s1 && (hi_s1 == HI_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= '0;
    else        sel <= dec;
  end

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R5
  sel_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0) |-> !$past(cs_n_s1));

endmodule

// File: rtl/hbus_edge_strobe.sv
// Strobe generation from the second stage and its delayed copy.
module hbus_edge_strobe
  import hbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  hb_ctl_t ctl_s2,
  input  hb_ctl_t ctl_s3,
  input  logic    sel_any,
  output logic    rd_stb,
  output logic    wr_stb
);

  logic oe_rise;
  logic we_fall;

  assign oe_rise = hb_rise(ctl_s3.oe_n, ctl_s2.oe_n);
  assign we_fall = hb_fall(ctl_s3.we_n, ctl_s2.we_n);

  assign rd_stb = oe_rise;
  assign wr_stb = we_fall & sel_any;

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  // R7
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R8
  wr_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sel_any);

endmodule

// File: rtl/hbus_front.sv
module hbus_front
  import hbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LOW_W  = 6,
  localparam int unsigned HI_W  = ADDR_W - LOW_W,
  localparam int unsigned NDEV  = 1 << HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [LOW_W-1:0]  dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  output logic [NDEV-1:0]   dev_sel,
  output logic              dev_rd_stb,
  output logic              dev_wr_stb,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en
);

  // Control: pad stage, pipeline stage, delayed copy for edge detection.
  hb_ctl_t                ctl_in;
  logic [2:0][2:0]        ctl_taps;
  hb_ctl_t                ctl_s1, ctl_s2, ctl_s3;

  assign ctl_in = '{cs_n: bus_cs_n, oe_n: bus_oe_n, we_n: bus_we_n};

  hbus_pipe #(.W(3), .STAGES(3), .RST(HB_CTL_IDLE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_in), .taps(ctl_taps)
  );

  assign ctl_s1 = hb_ctl_t'(ctl_taps[0]);
  assign ctl_s2 = hb_ctl_t'(ctl_taps[1]);
  assign ctl_s3 = hb_ctl_t'(ctl_taps[2]);

  // Address: two stages; select decode registered from stage one.
  logic [1:0][ADDR_W-1:0] addr_taps;

  hbus_pipe #(.W(ADDR_W), .STAGES(2), .RST('0)) u_addr (
    .clk(clk), .rst_n(rst_n), .d(bus_addr), .taps(addr_taps)
  );

  assign dev_addr = addr_taps[1][LOW_W-1:0];

  hbus_cs_decode #(.HI_W(HI_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s1(ctl_s1.cs_n),
    .hi_s1(addr_taps[0][ADDR_W-1:LOW_W]),
    .sel(dev_sel)
  );

  // Write data: two stages.
  logic [1:0][DATA_W-1:0] data_taps;

  hbus_pipe #(.W(DATA_W), .STAGES(2), .RST('0)) u_data (
    .clk(clk), .rst_n(rst_n), .d(bus_din), .taps(data_taps)
  );

  assign dev_wdata = data_taps[1];

  // Strobes, aligned with stage two.
  logic sel_any;
  assign sel_any = |dev_sel;

  hbus_edge_strobe u_stb (
    .clk(clk), .rst_n(rst_n),
    .ctl_s2(ctl_s2), .ctl_s3(ctl_s3),
    .sel_any(sel_any),
    .rd_stb(dev_rd_stb), .wr_stb(dev_wr_stb)
  );

  // Registered read return path.
  logic rd_active_s2;
  assign rd_active_s2 = ~ctl_s2.oe_n & ~ctl_s2.cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
    end else begin
      bus_dout    <= dev_rdata;
      bus_dout_en <= rd_active_s2;
    end
  end

  // R10
  dout_en_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> $past(sel_any));

  // R9
  dout_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (bus_dout == $past(dev_rdata)));

endmodule

// File: tb/sim_hbus_front.sv
module sim_hbus_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_din = '0;
  logic [15:0] dev_rdata = '0;
  logic [5:0]  dev_addr;
  logic [15:0] dev_wdata;
  logic [3:0]  dev_sel;
  logic        dev_rd_stb, dev_wr_stb;
  logic [15:0] bus_dout;
  logic        bus_dout_en;

  always #2 clk = ~clk;

  hbus_front u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_din(bus_din), .dev_rdata(dev_rdata),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_sel(dev_sel),
    .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit dout_chk_on = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic [5:0]  addr;
    logic [15:0] wdata;
    logic [3:0]  sel;
    logic        rd;
    logic        wr;
    logic        en;
  } exp_t;

  exp_t q[$];
  logic prev_cs = 1, prev_oe = 1, prev_we = 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [15:0] rdata_of(input int c);
    return 16'h5A00 ^ 16'(c);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) dev_rdata <= rdata_of(cyc);

  // Driver: one bus sample per call; queues what stage two must show.
  task automatic drive(input logic cs, input logic oe, input logic we,
                       input logic [7:0] a, input logic [15:0] d);
    exp_t e;
    @(negedge clk);
    bus_cs_n = cs; bus_oe_n = oe; bus_we_n = we; bus_addr = a; bus_din = d;
    e.due   = cyc + 2;
    e.addr  = a[5:0];
    e.wdata = d;
    e.sel   = cs ? 4'b0 : (4'b1 << a[7:6]);
    e.rd    = oe & ~prev_oe;
    e.wr    = ~we & prev_we & ~cs;
    e.en    = ~prev_oe & ~prev_cs;
    q.push_back(e);
    prev_cs = cs; prev_oe = oe; prev_we = we;
  endtask

  // Monitor: compare stage-two outputs against queued expectations.
  always @(negedge clk) begin
    if (dout_chk_on) check("R9 bus_dout", 32'(bus_dout), 32'(rdata_of(cyc - 1)));
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check("R2 dev_addr", 32'(dev_addr), 32'(e.addr));
      check("R3 dev_wdata", 32'(dev_wdata), 32'(e.wdata));
      check("R4/R5 dev_sel", 32'(dev_sel), 32'(e.sel));
      check("R6 dev_rd_stb", 32'(dev_rd_stb), 32'(e.rd));
      check("R7/R8 dev_wr_stb", 32'(dev_wr_stb), 32'(e.wr));
      check("R10 bus_dout_en", 32'(bus_dout_en), 32'(e.en));
    end
  end

  task automatic write_burst(input logic [7:0] a, input logic [15:0] d, input int low_len);
    drive(0, 1, 1, a, d);
    for (int i = 0; i < low_len; i++) drive(0, 1, 0, a, d);
    drive(0, 1, 1, a, d);
    drive(1, 1, 1, 8'h00, 16'h0);
  endtask

  task automatic read_burst(input logic [7:0] a, input int low_len);
    drive(0, 1, 1, a, 16'h0);
    for (int i = 0; i < low_len; i++) drive(0, 0, 1, a, 16'h0);
    drive(0, 1, 1, a, 16'h0);
    drive(1, 1, 1, 8'h00, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs inactive in reset
    check("R1 dev_sel", 32'(dev_sel), 0);
    check("R1 dev_rd_stb", 32'(dev_rd_stb), 0);
    check("R1 dev_wr_stb", 32'(dev_wr_stb), 0);
    check("R1 bus_dout_en", 32'(bus_dout_en), 0);
    check("R1 dev_addr", 32'(dev_addr), 0);
    check("R1 dev_wdata", 32'(dev_wdata), 0);
    check("R1 bus_dout", 32'(bus_dout), 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 1, 1, 8'h00, 16'h0);
    dout_chk_on = 1;

    // Writes to every device, varying low length (R4, R7)
    for (int k = 0; k < 4; k++)
      write_burst(8'((k << 6) | (k * 5 + 3)), 16'hC000 + 16'(k * 16'h111), k + 1);
    // Reads from every device, short and long (R6, R10)
    for (int k = 0; k < 4; k++)
      read_burst(8'((k << 6) | (63 - k)), 4 - k);
    // R8: write-enable toggles without chip select
    drive(1, 1, 1, 8'h80, 16'h1234);
    drive(1, 1, 0, 8'h80, 16'h1234);
    drive(1, 1, 0, 8'h80, 16'h1234);
    drive(1, 1, 1, 8'h80, 16'h1234);
    drive(1, 1, 0, 8'h40, 16'h4321);
    drive(1, 1, 1, 8'h40, 16'h4321);
    // R7: back-to-back write pulses one cycle apart
    drive(0, 1, 0, 8'hC1, 16'hAAAA);
    drive(0, 1, 1, 8'hC2, 16'hBBBB);
    drive(0, 1, 0, 8'hC3, 16'hCCCC);
    drive(0, 1, 1, 8'hC4, 16'hDDDD);
    // R7: chip select and write enable fall in the same sample
    drive(1, 1, 1, 8'h45, 16'h0F0F);
    drive(0, 1, 0, 8'h45, 16'hF0F0);
    drive(0, 1, 1, 8'h45, 16'hF0F0);
    // R6: output-enable rise after chip select dropped
    drive(0, 0, 1, 8'h02, 16'h0);
    drive(1, 1, 1, 8'h02, 16'h0);
    for (int i = 0; i < 5; i++) drive(1, 1, 1, 8'h00, 16'h0);
    repeat (4) @(negedge clk);
    check("queue drained", 32'(q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule